// File: doc/BRIEF.md
# Pin Interrupt Detector with Debounce Filter

This block watches sixteen already-synchronized input pin levels and turns selected activity on them into one interrupt request. For each pin, software picks one trigger: a rising edge, a falling edge, either edge, a steady high level or a steady low level. A pin that fires sets its own bit in a sticky pending register. The pending bits stay set until software writes ones to them. The request line is high whenever any pending bit is set.

Noisy pins can be sent through a debounce filter, chosen pin by pin. All filters of the port share one sampling strobe. The strobe period is a power of two, from 1 to 32768 ticks. Those ticks are either system clock cycles or pulses on a slow clock-enable input. A filtered pin takes a new level only when two successive samples, one sampling period apart, agree on it.

A port-wide always-on control sets when the edge detectors run. When it is set, every pin's detector tracks its level all the time. When it is clear, a pin's detector tracks its level only while that pin has an interrupt enable set. If the level changed while the detector was stopped, that change is reported as an edge once the pin is enabled.

Top module: `pin_irq_unit`

## Requirements
- R1: `irq_en` bit n enables falling-edge (or low-level) detection for pin n, and bit n+16 enables rising-edge (or high-level) detection. With `irq_type[n]`=0 (edge), setting only the upper bit reports rising edges, setting only the lower bit reports falling edges, and setting both reports both edges. Pins without enables never set a pending bit.
- R2: With `irq_type[n]`=1 (level), the upper enable bit reports a high level and the lower enable bit reports a low level. The pending bit is set again on every cycle the active level is present, so a clear during that level leaves it set.
- R3: Pulsing `clr_we` clears every pending bit whose `clr_bits` bit is 1, and bits written as 0 keep their value. A detection on the same cycle as a clear of that bit leaves the bit set.
- R4: `irq` is 1 exactly when at least one bit of `status` is 1. Both outputs are registered and change on the same clock edge.
- R5: A pin whose `db_en` bit is 0 bypasses the filter. A level change applied before a clock edge sets its pending bit in the `status` value registered at that edge.
- R6: A filtered pin (`db_en` bit 1) takes a new level only after two successive samples, one sampling period apart, agree. A pulse shorter than one sampling period is ignored.
- R7: With `db_src`=0, the sampling period is 2^`db_sel` system clock cycles (1 for `db_sel`=0 up to 32768 for `db_sel`=15). A filtered rising edge therefore sets its pending bit no earlier than the (P+2)-th edge and no later than the (2P+1)-th edge after the change, where P is the period.
- R8: With `db_src`=1, the sampling period is 2^`db_sel` pulses of `slow_tick` instead of system clock cycles.
- R9: With `det_always_on`=1, every pin's edge detector tracks its level continuously. With it 0, a pin's detector holds its last level while both of its enables are 0, so a change made during that time is reported as an edge once an enable is set.
- R10: A synchronous `rst` clears `status` and `irq` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 16 | Synchronized pin levels |
| irq_en | input | 32 | Enables: bit n low/falling, bit n+16 high/rising for pin n |
| irq_type | input | 16 | Per pin: 0 edge, 1 level |
| db_en | input | 16 | Per pin: 1 routes the pin through the debounce filter |
| db_sel | input | 4 | Sampling period exponent, period = 2^db_sel ticks |
| db_src | input | 1 | Sampling tick source: 0 system clock, 1 slow_tick |
| det_always_on | input | 1 | 1: all edge detectors always track their pins |
| slow_tick | input | 1 | Slow clock-enable pulse, one cycle wide |
| clr_we | input | 1 | Write strobe for clearing pending bits |
| clr_bits | input | 16 | Write-one-to-clear mask for pending bits |
| status | output | 16 | Sticky pending bits |
| irq | output | 1 | Combined interrupt request |

## Verification
The detection logic is swept over every pin and every one of the five trigger settings. Each run goes through four steps: a quiet low level, a rise, a clear while the pin is high, and a fall. This separates the edge settings from the level settings and shows that only the addressed pin responds. The filter is driven with steady level changes at several sampling exponents, including the largest. Each change is checked against the earliest and latest cycles at which the pending bit may appear, and pulses one cycle shorter than the period must be ignored. This separates the period from the clock source, and filtered pins from bypassed ones. Further patterns cover a clear on the same cycle as a detection, a write of zero, and a pin that changes level while its detector is stopped, run once with always-on and once without.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  // sampling tick source for the debounce strobe
  typedef enum logic {
    SRC_SYS  = 1'b0,
    SRC_SLOW = 1'b1
  } dbsrc_e;
endpackage

// File: rtl/irq_sample_tick.sv
// Shared debounce sampling strobe: one pulse every 2^sel counter ticks.
module irq_sample_tick #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_slow,
  input  logic             slow_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             strobe
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             cen;
  logic             strobe_q;

  assign cen = src_slow ? slow_tick : 1'b1;

  // limit = 2^sel - 1: bit b is set when b lies below sel
  always_comb begin
    for (int b = 0; b < CNT_W; b++) begin
      lim[b] = (b < int'(sel));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      if (cen) begin
        // >= also wraps a count left above a newly lowered limit
        if (cnt_q >= lim) begin
          cnt_q    <= '0;
          strobe_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign strobe = strobe_q;

  // R8: a strobe only follows a cycle in which the selected source ticked
  p_strobe_needs_tick_r8: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> $past(cen));
endmodule

// File: rtl/irq_pin_filter.sv
// Two-sample agreement filter for one pin.
module irq_pin_filter (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic raw,
  output logic filt
);
  logic samp_q;
  logic filt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q <= 1'b0;
      filt_q <= 1'b0;
    end else if (strobe) begin
      samp_q <= raw;
      if (raw == samp_q) begin
        filt_q <= raw;
      end
    end
  end

  assign filt = filt_q;

  // R6: the filtered level moves only on a sampling strobe
  p_filter_holds_r6: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(filt_q));
  // R6: a sample that disagrees with the previous one never moves the output
  p_filter_agree_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe && (raw != samp_q)) |=> $stable(filt_q));
endmodule

// File: rtl/irq_pin_detect.sv
// Edge / level trigger for one pin; hit is valid in the current cycle.
module irq_pin_detect (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic en_hi,
  input  logic en_lo,
  input  logic lvl_mode,
  input  logic always_on,
  output logic hit
);
  logic prev_q;
  logic active;

  assign active = always_on | en_hi | en_lo;

  // previous-level register is held while the detector is stopped
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
    end else if (active) begin
      prev_q <= lvl;
    end
  end

  always_comb begin
    if (lvl_mode) begin
      hit = (en_hi & lvl) | (en_lo & ~lvl);
    end else begin
      hit = (en_hi & lvl & ~prev_q) | (en_lo & ~lvl & prev_q);
    end
  end

  // R9: a stopped detector keeps its remembered level
  p_prev_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    !(always_on || en_hi || en_lo) |=> $stable(prev_q));
endmodule

// File: rtl/irq_status_reg.sv
// Sticky pending bits with write-one-to-clear and a combined request.
module irq_status_reg #(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] hit,
  input  logic              clr_we,
  input  logic [N_PINS-1:0] clr_bits,
  output logic [N_PINS-1:0] status,
  output logic              irq
);
  logic [N_PINS-1:0] st_q;
  logic [N_PINS-1:0] st_next;
  logic [N_PINS-1:0] clr_mask;
  logic              irq_q;

  assign clr_mask = clr_we ? clr_bits : '0;
  // a detection overrides a clear of the same bit
  assign st_next  = (st_q & ~clr_mask) | hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_next;
      irq_q <= |st_next;
    end
  end

  assign status = st_q;
  assign irq    = irq_q;

  // R3: a pending bit survives unless a one was written to it
  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(st_q) & ~(($past(clr_we)) ? $past(clr_bits) : '0) & ~st_q) == '0));
  // R3: a detection always lands, even against a clear
  p_hit_wins_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(hit) & ~st_q) == '0));
  // R1: a pending bit rises only after its pin fired
  p_set_needs_hit_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(hit)) == '0));
  // R4: request line matches the pending bits
  p_irq_or_r4: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|st_q));
endmodule

// File: rtl/pin_irq_unit.sv
// Per-port pin interrupt detector with optional debounce.
module pin_irq_unit #(
  parameter int N_PINS = 16,
  parameter int SEL_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PINS-1:0]   pin_lvl,
  input  logic [2*N_PINS-1:0] irq_en,
  input  logic [N_PINS-1:0]   irq_type,
  input  logic [N_PINS-1:0]   db_en,
  input  logic [SEL_W-1:0]    db_sel,
  input  logic                db_src,
  input  logic                det_always_on,
  input  logic                slow_tick,
  input  logic                clr_we,
  input  logic [N_PINS-1:0]   clr_bits,
  output logic [N_PINS-1:0]   status,
  output logic                irq
);
  logic              strobe;
  logic              src_slow;
  logic [N_PINS-1:0] filt;
  logic [N_PINS-1:0] eff;
  logic [N_PINS-1:0] hit;

  assign src_slow = (db_src == pirq_pkg::SRC_SLOW);

  irq_sample_tick #(.SEL_W(SEL_W)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .src_slow  (src_slow),
    .slow_tick (slow_tick),
    .sel       (db_sel),
    .strobe    (strobe)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    irq_pin_filter u_filt (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe),
      .raw    (pin_lvl[i]),
      .filt   (filt[i])
    );

    assign eff[i] = db_en[i] ? filt[i] : pin_lvl[i];

    irq_pin_detect u_det (
      .clk       (clk),
      .rst       (rst),
      .lvl       (eff[i]),
      .en_hi     (irq_en[i + N_PINS]),
      .en_lo     (irq_en[i]),
      .lvl_mode  (irq_type[i]),
      .always_on (det_always_on),
      .hit       (hit[i])
    );
  end

  irq_status_reg #(.N_PINS(N_PINS)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .clr_we   (clr_we),
    .clr_bits (clr_bits),
    .status   (status),
    .irq      (irq)
  );
endmodule

// File: tb/pin_irq_unit_tb_top.sv
module pin_irq_unit_tb_top;
  localparam int CLK_P     = 10;
  localparam int NP        = 16;
  localparam int WD_CYCLES = 150000;
  localparam int TICK_DIV  = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [NP-1:0] pin_lvl;
  logic [2*NP-1:0] irq_en;
  logic [NP-1:0] irq_type;
  logic [NP-1:0] db_en;
  logic [3:0]    db_sel;
  logic          db_src;
  logic          det_always_on;
  logic          slow_tick;
  logic          clr_we;
  logic [NP-1:0] clr_bits;
  logic [NP-1:0] status;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  pin_irq_unit dut_i (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .irq_en(irq_en),
    .irq_type(irq_type), .db_en(db_en), .db_sel(db_sel), .db_src(db_src),
    .det_always_on(det_always_on), .slow_tick(slow_tick),
    .clr_we(clr_we), .clr_bits(clr_bits), .status(status), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  // slow clock-enable: one cycle high every TICK_DIV cycles
  initial begin
    int tdiv;
    tdiv = 0;
    slow_tick = 1'b0;
    forever begin
      @(negedge clk);
      tdiv = (tdiv == TICK_DIV-1) ? 0 : tdiv + 1;
      slow_tick = (tdiv == 0);
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_bits = '1;
    step();
    clr_we = 1'b0; clr_bits = '0;
  endtask

  task automatic check(input string tag, input logic [NP-1:0] exp);
    n_cmp++;
    if (status !== exp || irq !== (exp != '0)) begin
      n_bad++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b (irq as OR per R4)",
               tag, status, irq, exp, (exp != '0));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    logic [NP-1:0] bit_i;
    logic [NP-1:0] exp;
    bit hi, lo, lv;
    int sels [7] = '{0, 1, 2, 3, 4, 5, 15};
    int per;

    rst = 1'b1; pin_lvl = '0; irq_en = '0; irq_type = '0; db_en = '0;
    db_sel = '0; db_src = 1'b0; det_always_on = 1'b1;
    clr_we = 1'b0; clr_bits = '0;
    steps(3);
    rst = 1'b0;
    check("R10 reset state", '0);
    step();
    check("R10 idle after reset", '0);

    // synchronous reset while a bit is pending
    irq_en[16+2] = 1'b1; pin_lvl[2] = 1'b1;
    step();
    check("R10 pending before reset", 16'h0004);
    rst = 1'b1;
    step();
    rst = 1'b0; irq_en = '0; pin_lvl = '0;
    check("R10 mid-run reset", '0);
    step();
    clear_all();

    // R1 / R2 sweep: every pin, every trigger setting (bypassed filter)
    for (int i = 0; i < NP; i++) begin
      for (int m = 0; m < 5; m++) begin
        bit_i = '0; bit_i[i] = 1'b1;
        hi = (m == 0) || (m == 2) || (m == 3);
        lo = (m == 1) || (m == 2) || (m == 4);
        lv = (m >= 3);
        irq_en = '0; irq_type = '0; pin_lvl = '0;
        clear_all();
        if (hi) irq_en[i+NP] = 1'b1;
        if (lo) irq_en[i] = 1'b1;
        if (lv) irq_type[i] = 1'b1;
        steps(2);
        exp = (m == 4) ? bit_i : '0;
        check(lv ? "R2 quiet low" : "R1 quiet low", exp);
        pin_lvl[i] = 1'b1;
        step();
        exp = (m != 1) ? bit_i : '0;
        check(lv ? "R2 after rise" : "R1 after rise (R5 bypass)", exp);
        clear_all();
        step();
        exp = (m == 3) ? bit_i : '0;
        check(lv ? "R2 clear while level held" : "R1 clear while high", exp);
        pin_lvl[i] = 1'b0;
        step();
        exp = (m != 0) ? bit_i : '0;
        check(lv ? "R2 after fall" : "R1 after fall", exp);
      end
    end
    irq_en = '0; irq_type = '0; pin_lvl = '0;
    clear_all();

    // R3: write zero, partial clear, detect-and-clear collision
    irq_en[16+5] = 1'b1; irq_en[16+9] = 1'b1;
    step();
    pin_lvl[5] = 1'b1;
    step();
    check("R3 pin5 pending", 16'h0020);
    clr_we = 1'b1; clr_bits = '0;
    step();
    clr_we = 1'b0;
    check("R3 write of zero keeps bit", 16'h0020);
    pin_lvl[9] = 1'b1; clr_we = 1'b1; clr_bits = 16'h0220;
    step();
    clr_we = 1'b0; clr_bits = '0;
    check("R3 detection wins over same-cycle clear", 16'h0200);
    clr_we = 1'b1; clr_bits = 16'h0200;
    step();
    clr_we = 1'b0; clr_bits = '0;
    check("R3 single-bit clear", '0);
    irq_en = '0; pin_lvl = '0;
    clear_all();

    // R9: detector stopped vs always on
    det_always_on = 1'b0;
    steps(2);
    pin_lvl[3] = 1'b1;
    steps(3);
    check("R9 no enables, no pending", '0);
    irq_en[16+3] = 1'b1;
    step();
    check("R9 stale level reported as edge", 16'h0008);
    irq_en = '0; pin_lvl[3] = 1'b0; det_always_on = 1'b1;
    clear_all();
    steps(3);
    pin_lvl[3] = 1'b1;
    steps(3);
    irq_en[16+3] = 1'b1;
    step();
    check("R9 always-on tracked, no edge", '0);
    irq_en = '0; pin_lvl = '0;
    steps(2);
    clear_all();

    // R6 / R7: system-clock sampling, several periods
    db_src = 1'b0; db_en = 16'h0001;
    db_sel = 4'd0;
    steps(8);
    for (int s = 0; s < 7; s++) begin
      per = 1 << sels[s];
      db_sel = 4'(sels[s]);
      irq_en = '0; irq_en[16] = 1'b1;
      clear_all();
      if (per >= 2 && sels[s] != 15) begin
        pin_lvl[0] = 1'b1;
        steps(per - 1);
        pin_lvl[0] = 1'b0;
        steps(2*per + 4);
        check("R6 short pulse ignored", '0);
      end
      pin_lvl[0] = 1'b1;
      steps(per + 1);
      check("R7 not before earliest sample pair", '0);
      steps(per);
      check("R7 set by latest sample pair", 16'h0001);
      db_sel = 4'd0; pin_lvl[0] = 1'b0;
      steps(8);
    end

    // R8: slow tick source, period 2 ticks of TICK_DIV cycles
    db_src = 1'b1; db_sel = 4'd1;
    steps(40);
    clear_all();
    pin_lvl[0] = 1'b1;
    steps(2*TICK_DIV + 1);
    check("R8 slow source not yet sampled", '0);
    steps(2*TICK_DIV);
    check("R8 slow source sampled twice", 16'h0001);
    pin_lvl = '0; db_src = 1'b0; db_sel = 4'd0;
    steps(8);

    // R5: one pin bypassed, its neighbour filtered (period 8)
    db_sel = 4'd3; db_en = 16'hFF7F;
    irq_en = '0; irq_en[16+6] = 1'b1; irq_en[16+7] = 1'b1;
    steps(30);
    clear_all();
    pin_lvl[6] = 1'b1; pin_lvl[7] = 1'b1;
    step();
    check("R5 bypassed pin immediate, filtered pin waits", 16'h0080);
    steps(16);
    check("R5 filtered pin reported by 2P+1 (R6)", 16'h00C0);

    finish_run();
  end
endmodule